// File: doc/BRIEF.md
# Nonvolatile Byte Array Program/Erase Sequencer

This block sits between a simple synchronous register bus and an on-chip nonvolatile byte array. It holds one 8-bit control register and address/data latches. It drives the array's high-voltage enable, an operation-type select, a power-down line and a plain read port. Software opens a latch window, stores a target address and data by writing to the array's address space, and then sets a start bit. The start bit drives high voltage onto the array for the chosen operation, which is a program or one of three erase sizes.

Hardware interlocks keep the sequence in order. Start cannot be set without an open latch window and a valid latched address. The latch window cannot be closed while high voltage is applied. Reading the array while a cycle is running aborts that cycle and raises a sticky error. When auto timing is on, a down-counter ends each operation after a per-operation number of clock cycles. When it is off, software ends the operation.

Top module: `nvm_pe_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `arr_hv_en` is 0 and `err_flag` is 0.
- R2: The control register bits are 7 = spare, 6 = always 0, 5 = power-down, 4:3 = operation, 2 = latch window, 1 = auto timing and 0 = start. While start is 0, bits 7, 5, 4, 3, 2 and 1 read back as written and bit 6 reads 0. The spare bit changes no output other than its own read value.
- R3: With the latch window at 0, an array read returns the array data at `bus_addr`. An array write changes neither `arr_addr` nor `arr_wdata`. With the window at 1 and start at 0, an array write copies the address to `arr_addr` and the data to `arr_wdata`. An array read then returns the latched data and copies the read address to `arr_addr`.
- R4: A control write with bit 0 set makes start 1 only when the latch window was already 1 before that write and the latched address is below DEPTH. Otherwise start stays 0.
- R5: `arr_hv_en` is 1 exactly while start is 1. `arr_op` equals register bits 4:3, where 00 = program, 01 = byte erase, 10 = block erase and 11 = bulk erase.
- R6: With auto timing on, start stays 1 for exactly T_PROG, T_BYTE, T_BLOCK or T_BULK cycles, according to the operation, and then clears itself. A control write in the last counted cycle does not extend the operation.
- R7: With auto timing off, start stays 1 until a control write with bit 0 clear.
- R8: A control write with bit 2 clear, made while start is 1, leaves the latch window at 1. If bit 0 is also clear, that write clears start.
- R9: An array read while start is 1 clears start in the next cycle and sets `err_flag`, and the latches keep their contents. This includes a read in the last auto-timed cycle.
- R10: `err_flag` stays set through later bus traffic and rejected start attempts. It clears only when start is successfully set.
- R11: While start is 1, control writes do not change power-down, operation or auto timing, and array writes do not change `arr_addr` or `arr_wdata`.
- R12: `arr_pd` follows bit 5. While power-down is 1, `arr_rd_en` stays 0 and unlatched array reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ctl | input | 1 | 1 = control register, 0 = array space |
| bus_addr | input | AW | Array byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| arr_addr | output | AW | Latched target address |
| arr_wdata | output | 8 | Latched target data |
| arr_hv_en | output | 1 | High-voltage enable to the array |
| arr_op | output | 2 | Operation select |
| arr_pd | output | 1 | Array power-down |
| arr_rd_en | output | 1 | Array read strobe |
| arr_rd_addr | output | AW | Array read address |
| arr_rdata | input | 8 | Array read data |
| err_flag | output | 1 | Sticky aborted-cycle flag |

## Verification
The auto-timer's expiry can fall in the same cycle as a bus access, either a control write that tries to close the latch window or an array read that aborts the cycle. The bench starts a timed bulk erase and a timed byte erase, idles for exactly one cycle less than the operation time, and issues that access in the final counted cycle. It then checks that high voltage is off and that the latch window stayed open, with the operation and auto bits kept. It also checks that the read in the final cycle still counted as an abort and raised the error flag.

// File: rtl/nvm_pe_ctrl.sv
module nvm_pe_ctrl #(
  parameter int unsigned AW      = 7,
  parameter int unsigned DEPTH   = 96,
  parameter int unsigned T_PROG  = 40,
  parameter int unsigned T_BYTE  = 30,
  parameter int unsigned T_BLOCK = 50,
  parameter int unsigned T_BULK  = 80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_wr,
  input  logic          bus_ctl,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    arr_wdata,
  output logic          arr_hv_en,
  output logic [1:0]    arr_op,
  output logic          arr_pd,
  output logic          arr_rd_en,
  output logic [AW-1:0] arr_rd_addr,
  input  logic [7:0]    arr_rdata,
  output logic          err_flag
);
  localparam int unsigned TM_A = (T_PROG > T_BYTE) ? T_PROG : T_BYTE;
  localparam int unsigned TM_B = (T_BLOCK > T_BULK) ? T_BLOCK : T_BULK;
  localparam int unsigned T_MAX = (TM_A > TM_B) ? TM_A : TM_B;
  localparam int unsigned CW = $clog2(T_MAX + 1);
  localparam logic [AW:0] LIMIT = DEPTH[AW:0];

  logic          spare_q, pd_q, lat_q, auto_q, start_q, vld_q, err_q;
  logic [1:0]    mode_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;

  wire ctl_wr  = bus_req & bus_wr & bus_ctl;
  wire arr_wr  = bus_req & bus_wr & ~bus_ctl;
  wire arr_rd  = bus_req & ~bus_wr & ~bus_ctl;
  wire addr_ok = {1'b0, bus_addr} < LIMIT;
  wire capture = lat_q & ~start_q & (arr_wr | arr_rd);
  wire set_ok  = ctl_wr & bus_wdata[0] & ~start_q & lat_q & vld_q;
  wire timeout = start_q & auto_q & (cnt_q == '0);
  wire abort   = arr_rd & start_q;
  wire lat_d   = ctl_wr ? (bus_wdata[2] | start_q) : lat_q;
  wire unused_wd6 = bus_wdata[6];

  function automatic logic [CW-1:0] op_len(input logic [1:0] m);
    case (m)
      2'b00:   op_len = CW'(T_PROG - 1);
      2'b01:   op_len = CW'(T_BYTE - 1);
      2'b10:   op_len = CW'(T_BLOCK - 1);
      default: op_len = CW'(T_BULK - 1);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spare_q <= 1'b0;
      pd_q    <= 1'b0;
      mode_q  <= 2'b00;
      auto_q  <= 1'b0;
      lat_q   <= 1'b0;
    end else begin
      lat_q <= lat_d;
      if (ctl_wr) spare_q <= bus_wdata[7];
      if (ctl_wr && !start_q) begin
        pd_q   <= bus_wdata[5];
        mode_q <= bus_wdata[4:3];
        auto_q <= bus_wdata[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else if (abort || timeout) start_q <= 1'b0;
    else if (ctl_wr) start_q <= start_q ? bus_wdata[0] : set_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (set_ok) cnt_q <= op_len(bus_wdata[4:3]);
    else if (start_q && auto_q && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (!lat_d) vld_q <= 1'b0;
      else if (capture) vld_q <= addr_ok;
      if (capture) addr_q <= bus_addr;
      if (capture && arr_wr) data_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (set_ok) err_q <= 1'b0;
    else if (abort) err_q <= 1'b1;
  end

  wire [7:0] ctl_val = {spare_q, 1'b0, pd_q, mode_q, lat_q, auto_q, start_q};

  assign bus_rdata   = bus_ctl ? ctl_val : lat_q ? data_q : pd_q ? 8'h00 : arr_rdata;
  assign arr_addr    = addr_q;
  assign arr_wdata   = data_q;
  assign arr_hv_en   = start_q;
  assign arr_op      = mode_q;
  assign arr_pd      = pd_q;
  assign arr_rd_en   = arr_rd & ~lat_q & ~pd_q;
  assign arr_rd_addr = bus_addr;
  assign err_flag    = err_q;
endmodule

// File: rtl/nvm_pe_ctrl_chk.sv
module nvm_pe_ctrl_chk #(
  parameter int unsigned LIM = 80
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_wr,
  input logic       bus_ctl,
  input logic [7:0] bus_wdata,
  input logic       start,
  input logic       lat,
  input logic       vld,
  input logic       auto_on,
  input logic [1:0] mode,
  input logic       err
);
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 0;
    else if (start && auto_on) run_q <= run_q + 1;
    else run_q <= 0;
  end

  a_r4_start_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |-> $past(lat) && $past(vld));

  a_r8_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
    start && bus_req && bus_wr && bus_ctl && !bus_wdata[2] |=> lat);

  a_r9_read_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    start && bus_req && !bus_wr && !bus_ctl |=> !start && err);

  a_r10_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $rose(start));

  a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    start && $past(start) |-> $stable(mode));

  a_r6_auto_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    start && auto_on |-> run_q < LIM);
endmodule

bind nvm_pe_ctrl nvm_pe_ctrl_chk #(.LIM(T_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_ctl(bus_ctl),
  .bus_wdata(bus_wdata), .start(start_q), .lat(lat_q), .vld(vld_q),
  .auto_on(auto_q), .mode(mode_q), .err(err_q)
);

// File: tb/nvm_pe_ctrl_tb.sv
`timescale 1ns/1ps
module nvm_pe_ctrl_tb;
  localparam int AW = 5, DEPTH = 24;
  localparam int TP = 6, TB = 4, TK = 9, TU = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_wr = 1'b0, bus_ctl = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, arr_wdata, arr_rdata;
  logic [AW-1:0] arr_addr, arr_rd_addr;
  logic arr_hv_en, arr_pd, arr_rd_en, err_flag;
  logic [1:0] arr_op;
  logic [7:0] rd;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3);
  endfunction

  assign arr_rdata = arr_rd_en ? pat(int'(arr_rd_addr)) : 8'hEE;

  nvm_pe_ctrl #(.AW(AW), .DEPTH(DEPTH), .T_PROG(TP), .T_BYTE(TB), .T_BLOCK(TK), .T_BULK(TU)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_ctl(bus_ctl),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_hv_en(arr_hv_en), .arr_op(arr_op),
    .arr_pd(arr_pd), .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr),
    .arr_rdata(arr_rdata), .err_flag(err_flag));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic c, input logic w, input logic [AW-1:0] a, input logic [7:0] d);
    bus_req = 1'b1; bus_wr = w; bus_ctl = c; bus_addr = a; bus_wdata = d;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wrc(input logic [7:0] d); acc(1'b1, 1'b1, '0, d); endtask
  task automatic rdc(); acc(1'b1, 1'b0, '0, 8'h00); endtask

  function automatic int tlen(input int m);
    return (m == 0) ? TP : (m == 1) ? TB : (m == 2) ? TK : TU;
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hv", arr_hv_en, 0);
    chk("R1 err", err_flag, 0);
    rdc(); chk("R1 reg", rd, 8'h00);

    for (int v = 0; v < 256; v += 2) begin
      wrc(8'(v));
      chk("R2 hv", arr_hv_en, 0);
      chk("R12 pd", arr_pd, (v >> 5) & 1);
      chk("R5 op", arr_op, (v >> 3) & 3);
      rdc(); chk("R2 readback", rd, v & 8'hBE);
    end
    wrc(8'h00);

    for (int a = 0; a < 32; a++) begin
      acc(1'b0, 1'b0, 5'(a), 8'h00); chk("R3 unlatched read", rd, pat(a));
    end
    acc(1'b0, 1'b1, 5'd9, 8'hC3);
    chk("R3 no capture addr", arr_addr, 0);
    chk("R3 no capture data", arr_wdata, 0);
    wrc(8'h20);
    acc(1'b0, 1'b0, 5'd4, 8'h00); chk("R12 pd read", rd, 8'h00);
    wrc(8'h04);
    acc(1'b0, 1'b1, 5'd5, 8'h5A);
    chk("R3 cap addr", arr_addr, 5); chk("R3 cap data", arr_wdata, 8'h5A);
    acc(1'b0, 1'b0, 5'd9, 8'h00);
    chk("R3 latched read", rd, 8'h5A); chk("R3 read addr", arr_addr, 9);

    for (int a = 0; a < 32; a++) begin
      wrc(8'h04);
      acc(1'b0, 1'b1, 5'(a), 8'(a));
      wrc(8'h05);
      chk("R4 hv valid addr", arr_hv_en, a < DEPTH);
      rdc(); chk("R4 start bit", rd[0], a < DEPTH);
      wrc(8'h04);
    end
    wrc(8'h00);
    wrc(8'h05);
    rdc(); chk("R4 no latch window", rd, 8'h04);
    chk("R4 hv", arr_hv_en, 0);

    for (int m = 0; m < 4; m++) begin
      int n;
      wrc(8'h04);
      acc(1'b0, 1'b1, 5'd3, 8'h11);
      wrc(8'(8'h07 | (m << 3)));
      chk("R5 op during run", arr_op, m);
      n = 0;
      while (arr_hv_en && n < 100) begin n++; @(negedge clk); end
      chk("R6 auto length", n, tlen(m));
    end
    wrc(8'h00);

    wrc(8'h04); acc(1'b0, 1'b1, 5'd2, 8'h22); wrc(8'h05);
    repeat (40) @(negedge clk);
    chk("R7 manual hold", arr_hv_en, 1);
    wrc(8'h00);
    chk("R7 manual clear", arr_hv_en, 0);
    rdc(); chk("R8 latch kept", rd, 8'h04);
    wrc(8'h00); rdc(); chk("R8 latch clears later", rd, 8'h00);

    wrc(8'h04); acc(1'b0, 1'b1, 5'd3, 8'h11); wrc(8'h1F);
    repeat (TU - 1) @(negedge clk);
    wrc(8'h00);
    chk("R6 coincident write ends run", arr_hv_en, 0);
    rdc(); chk("R8 coincident latch kept", rd, 8'h1E);
    wrc(8'h00);

    wrc(8'h04); acc(1'b0, 1'b1, 5'd7, 8'h33); wrc(8'h05);
    acc(1'b0, 1'b0, 5'd12, 8'h00);
    chk("R9 read data", rd, 8'h33);
    chk("R9 hv off", arr_hv_en, 0); chk("R9 err", err_flag, 1);
    chk("R9 addr kept", arr_addr, 7);
    wrc(8'h00); chk("R10 err sticky", err_flag, 1);
    wrc(8'h01); chk("R10 err after reject", err_flag, 1);
    rdc(); chk("R10 reject reg", rd, 8'h00);
    wrc(8'h04); acc(1'b0, 1'b1, 5'd2, 8'h44); wrc(8'h05);
    chk("R10 err cleared", err_flag, 0);
    wrc(8'h04);

    acc(1'b0, 1'b1, 5'd3, 8'h11); wrc(8'h0F);
    repeat (TB - 1) @(negedge clk);
    acc(1'b0, 1'b0, 5'd1, 8'h00);
    chk("R9 last cycle abort", err_flag, 1);
    chk("R9 last cycle hv", arr_hv_en, 0);
    wrc(8'h04);

    acc(1'b0, 1'b1, 5'd6, 8'h66); wrc(8'h0D);
    wrc(8'h33);
    rdc(); chk("R11 fields frozen", rd, 8'h0D);
    chk("R11 pd frozen", arr_pd, 0);
    acc(1'b0, 1'b1, 5'd2, 8'h77);
    chk("R11 addr frozen", arr_addr, 6); chk("R11 data frozen", arr_wdata, 8'h66);
    chk("R11 op frozen", arr_op, 1);
    wrc(8'h04); wrc(8'h00);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule